// File: doc/BRIEF.md
# Watchdog Timer With Safe-Frequency Fallback

This block guards a clock generator's frequency selection. Once enabled, it counts down a programmed number of time-base steps. Each step lasts a short period or twice that period, chosen by a select pin. Software reloads the countdown by writing a new step count, and that write is the service kick. If no kick arrives before the count runs out, the block raises a sticky alarm flag. It then replaces the normal frequency code on its output with a safe code and drives an active-low system reset pulse.

The safe code has two possible sources: the frequency code latched from hardware straps, or a 5-bit field that software programs. A source-select pin chooses between them. The watchdog enable is sampled from a hardware pin in the first clock after reset. Software can override the sampled value at any later time by writing its own enable bit. Any change of the output frequency code also fires the reset pulse, so the system restarts whenever the clock selection moves. The PLL and the register interface sit outside this block. All pins are plain control and status levels or strobes, so no flow control applies.

Top module: `wdog_fallback`

## Requirements
- R1: While reset is asserted, and after it is released, `alarm` is 0 and `sys_rst_n` is 1. One clock after reset is released, `freq_code` equals `norm_code`.
- R2: A timeout lasts the step count times the step period. The step period is STEP_CYC clocks when `base_sel` is 1 and 2*STEP_CYC clocks when it is 0.
- R3: With no count write, the countdown starts at INIT_COUNT (default 16) steps after reset.
- R4: `hw_en_pin` is sampled once, in the first clock after reset, and later changes on the pin have no effect. A pulse on `sw_en_wr` loads `sw_en_val`, and from then on `sw_en_val` decides the enable in place of the sampled pin. While the watchdog is disabled, it never expires and its step phase holds at zero.
- R5: A pulse on `cnt_wr` loads `cnt_val` as the new step count and restarts the current step. The timeout is then measured from that write.
- R6: On expiry `alarm` becomes 1. It stays 1 until a pulse on `alarm_clr`. If expiry and clear arrive in the same cycle, expiry wins.
- R7: While `alarm` is 1, `freq_code` is the safe code. The safe code is `strap_code` when `safe_src_sel` is 0 and `safe_prog` when it is 1. While `alarm` is 0, `freq_code` follows `norm_code`.
- R8: An expiry, and any change of `freq_code` after the first clock following reset, drives `sys_rst_n` low. The pulse lasts RST_LEN clocks from its last trigger. An expiry that also changes the code gives RST_LEN+1 low clocks.
- R9: A step count of 0 behaves like a count of 1: the watchdog expires at the end of the first step.
- R10: After an expiry the countdown stays disarmed. No further expiry occurs until the next `cnt_wr`, even after the alarm is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en_pin | input | 1 | Hardware watchdog enable, sampled once after reset |
| sw_en_wr | input | 1 | Strobe that loads the software enable override |
| sw_en_val | input | 1 | Software enable value |
| base_sel | input | 1 | Step period select: 1 = short, 0 = long (twice the short period) |
| cnt_wr | input | 1 | Strobe that loads the step count (service kick) |
| cnt_val | input | CNT_W | Step count to load |
| safe_src_sel | input | 1 | Safe code source: 0 = strap code, 1 = programmed code |
| safe_prog | input | CODE_W | Programmed safe frequency code |
| strap_code | input | CODE_W | Frequency code latched from hardware straps |
| norm_code | input | CODE_W | Normal frequency code |
| alarm_clr | input | 1 | Strobe that clears the alarm flag |
| freq_code | output | CODE_W | Active frequency code |
| alarm | output | 1 | Sticky alarm status |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The assertions assume that `strap_code`, `safe_prog` and `safe_src_sel` are quasi-static configuration inputs, that RST_LEN is at least 2, and that each strobe is high for a single clock. The checks on the safe code compare `freq_code` with the safe-code inputs as they stood one clock earlier. The stimulus changes configuration only while the alarm is clear and drives every strobe for exactly one clock. It waits for each reset pulse to finish before the next scenario, so no trigger arrives while a pulse is still running unless a requirement calls for it.

// File: rtl/wdfb_pkg.sv
package wdfb_pkg;
  typedef enum logic {
    STEP_LONG  = 1'b0,
    STEP_SHORT = 1'b1
  } step_e;
endpackage

// File: rtl/wdfb_tick.sv
module wdfb_tick
  import wdfb_pkg::*;
#(
  parameter int unsigned STEP_CYC = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  restart,
  input  step_e step_sel,
  output logic  tick
);
  localparam int unsigned LONG_CYC = 2 * STEP_CYC;
  localparam int unsigned PH_W     = $clog2(LONG_CYC + 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] limit;

  // Last phase value of the current step.
  assign limit = (step_sel == STEP_SHORT) ? PH_W'(STEP_CYC - 1) : PH_W'(LONG_CYC - 1);
  assign tick  = run && (phase >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        phase <= '0;
    else if (restart || !run || tick)  phase <= '0;
    else                               phase <= phase + 1'b1;
  end
endmodule

// File: rtl/wdfb_count.sv
module wdfb_count #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned INIT_COUNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] remain;
  logic             armed;

  // Zero and one both end on the first step.
  assign expire = tick && armed && !load && (remain <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= CNT_W'(INIT_COUNT);
      armed  <= 1'b1;
    end else if (load) begin
      remain <= load_val;
      armed  <= 1'b1;
    end else if (expire) begin
      armed  <= 1'b0;
    end else if (tick && armed) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/wdfb_pulse.sv
module wdfb_pulse #(
  parameter int unsigned RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse_n
);
  localparam int unsigned LEN_W = $clog2(RST_LEN + 1);

  logic [LEN_W-1:0] left;

  assign pulse_n = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (trig)        left <= LEN_W'(RST_LEN);
    else if (left != '0)  left <= left - 1'b1;
  end
endmodule

// File: rtl/wdog_fallback.sv
module wdog_fallback
  import wdfb_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned STEP_CYC   = 1000,
  parameter int unsigned INIT_COUNT = 16,
  parameter int unsigned RST_LEN    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en_pin,
  input  logic              sw_en_wr,
  input  logic              sw_en_val,
  input  logic              base_sel,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              safe_src_sel,
  input  logic [CODE_W-1:0] safe_prog,
  input  logic [CODE_W-1:0] strap_code,
  input  logic [CODE_W-1:0] norm_code,
  input  logic              alarm_clr,
  output logic [CODE_W-1:0] freq_code,
  output logic              alarm,
  output logic              sys_rst_n
);
  logic              started;
  logic              hw_q;
  logic              sw_ovr;
  logic              sw_q;
  logic              en_eff;
  logic              tick;
  logic              expire;
  logic              code_chg;
  logic [CODE_W-1:0] safe_code;
  logic [CODE_W-1:0] code_next;

  // Enable: sampled pin until software writes its own bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      hw_q    <= 1'b0;
      sw_ovr  <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      started <= 1'b1;
      if (!started) hw_q <= hw_en_pin;
      if (sw_en_wr) begin
        sw_ovr <= 1'b1;
        sw_q   <= sw_en_val;
      end
    end
  end

  assign en_eff = started && (sw_ovr ? sw_q : hw_q);

  wdfb_tick #(.STEP_CYC(STEP_CYC)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_eff),
    .restart  (cnt_wr),
    .step_sel (step_e'(base_sel)),
    .tick     (tick)
  );

  wdfb_count #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .load_val (cnt_val),
    .tick     (tick),
    .expire   (expire)
  );

  // Sticky alarm, expiry has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alarm <= 1'b0;
    else if (expire)     alarm <= 1'b1;
    else if (alarm_clr)  alarm <= 1'b0;
  end

  assign safe_code = safe_src_sel ? safe_prog : strap_code;
  assign code_next = alarm ? safe_code : norm_code;
  assign code_chg  = started && (code_next != freq_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_code <= '0;
    else        freq_code <= code_next;
  end

  wdfb_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (expire || code_chg),
    .pulse_n (sys_rst_n)
  );
endmodule

// File: rtl/wdfb_check.sv
module wdfb_check #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alarm,
  input logic              alarm_clr,
  input logic [CODE_W-1:0] freq_code,
  input logic              sys_rst_n,
  input logic              safe_src_sel,
  input logic [CODE_W-1:0] safe_prog,
  input logic [CODE_W-1:0] strap_code,
  input logic              en_eff,
  input logic              started
);
  p_alarm_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm && !alarm_clr |=> alarm);

  p_rst_with_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> !sys_rst_n);

  p_safe_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> (freq_code == $past(safe_src_sel ? safe_prog : strap_code)));

  p_no_expiry_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> !$rose(alarm));

  p_code_change_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(started) && !$stable(freq_code) |-> !sys_rst_n);

  p_pulse_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |=> !sys_rst_n);
endmodule

bind wdog_fallback wdfb_check #(.CODE_W(CODE_W)) u_wdfb_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .alarm        (alarm),
  .alarm_clr    (alarm_clr),
  .freq_code    (freq_code),
  .sys_rst_n    (sys_rst_n),
  .safe_src_sel (safe_src_sel),
  .safe_prog    (safe_prog),
  .strap_code   (strap_code),
  .en_eff       (en_eff),
  .started      (started)
);

// File: tb/test_wdog_fallback.sv
module test_wdog_fallback;
  localparam int STEP = 20;
  localparam int LEN  = 8;
  localparam int INIT = 16;
  localparam logic [4:0] STRAP = 5'h0A;
  localparam logic [4:0] NORM  = 5'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_en_pin = 1'b1;
  logic       sw_en_wr = 1'b0, sw_en_val = 1'b0;
  logic       base_sel = 1'b1;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_val = '0;
  logic       safe_src_sel = 1'b0;
  logic [4:0] safe_prog = '0;
  logic [4:0] strap_code = STRAP;
  logic [4:0] norm_code = NORM;
  logic       alarm_clr = 1'b0;
  logic [4:0] freq_code;
  logic       alarm, sys_rst_n;

  int errors = 0;
  int checks = 0;
  int low_run = 0, last_len = 0, n_pulses = 0;

  always #5 clk = ~clk;

  wdog_fallback #(.STEP_CYC(STEP), .INIT_COUNT(INIT), .RST_LEN(LEN)) i_wdog_fallback (
    .clk(clk), .rst_n(rst_n), .hw_en_pin(hw_en_pin), .sw_en_wr(sw_en_wr),
    .sw_en_val(sw_en_val), .base_sel(base_sel), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .safe_src_sel(safe_src_sel), .safe_prog(safe_prog), .strap_code(strap_code),
    .norm_code(norm_code), .alarm_clr(alarm_clr), .freq_code(freq_code),
    .alarm(alarm), .sys_rst_n(sys_rst_n)
  );

  // Reset-pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!sys_rst_n) low_run <= low_run + 1;
    else if (low_run != 0) begin
      last_len <= low_run;
      n_pulses <= n_pulses + 1;
      low_run  <= 0;
    end
  end

  // base, count, src, prog, expected safe code
  localparam logic [19:0] VEC [5] = '{
    {1'b1, 8'd3, 1'b0, 5'h11, 5'h0A},
    {1'b0, 8'd2, 1'b1, 5'h15, 5'h15},
    {1'b1, 8'd5, 1'b1, 5'h1F, 5'h1F},
    {1'b0, 8'd1, 1'b0, 5'h04, 5'h0A},
    {1'b1, 8'd0, 1'b1, 5'h07, 5'h07}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] v);
    @(negedge clk);
    cnt_val = v; cnt_wr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic clear_alarm();
    @(negedge clk);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    wait_n(LEN + 4);
  endtask

  task automatic do_reset(input logic pin);
    hw_en_pin = pin;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    // R1 reset state
    wait_n(2);
    chk(alarm == 1'b0 && sys_rst_n == 1'b1, "R1 reset outputs", {alarm, sys_rst_n}, 1);
    rst_n = 1'b1;
    wait_n(2);
    chk(freq_code == NORM, "R1 code after reset", freq_code, NORM);

    // R3 default count, R2 short step, R7 strap source
    wait_n(INIT * STEP - 6);
    chk(alarm == 1'b0, "R3 no alarm before default timeout", alarm, 0);
    p0 = n_pulses;
    wait_n(8);
    chk(alarm == 1'b1, "R3 alarm at default timeout", alarm, 1);
    chk(freq_code == STRAP, "R7 strap safe code", freq_code, STRAP);
    wait_n(LEN + 4);
    chk(n_pulses == p0 + 1 && (last_len == LEN || last_len == LEN + 1),
        "R8 expiry reset pulse length", last_len, LEN);
    wait_n(50);
    chk(alarm == 1'b1, "R6 alarm sticky", alarm, 1);

    // R8 code change pulse on clear, R10 disarmed
    p0 = n_pulses;
    clear_alarm();
    chk(freq_code == NORM && n_pulses == p0 + 1 && last_len == LEN,
        "R8 code change pulse", last_len, LEN);
    wait_n(40 * STEP);
    chk(alarm == 1'b0, "R10 no re-expiry without write", alarm, 0);

    // R2 R7 R9 table
    for (int i = 0; i < 5; i++) begin
      int per, n;
      base_sel = VEC[i][19];
      safe_src_sel = VEC[i][10];
      safe_prog = VEC[i][9:5];
      per = VEC[i][19] ? STEP : 2 * STEP;
      n = (VEC[i][18:11] == 0) ? 1 : int'(VEC[i][18:11]);
      kick(VEC[i][18:11]);
      wait_n(n * per - 3);
      chk(alarm == 1'b0, $sformatf("R2 vector %0d early", i), alarm, 0);
      wait_n(6);
      chk(alarm == 1'b1, $sformatf("R2 R9 vector %0d expiry", i), alarm, 1);
      wait_n(3);
      chk(freq_code == VEC[i][4:0], $sformatf("R7 vector %0d safe code", i),
          freq_code, VEC[i][4:0]);
      clear_alarm();
    end

    // R5 kick restarts timeout
    base_sel = 1'b1;
    kick(8'd4);
    wait_n(50);
    kick(8'd4);
    wait_n(4 * STEP - 3);
    chk(alarm == 1'b0, "R5 kick postpones expiry", alarm, 0);
    wait_n(6);
    chk(alarm == 1'b1, "R5 expiry after last kick", alarm, 1);
    clear_alarm();

    // R4 software override
    @(negedge clk); sw_en_val = 1'b0; sw_en_wr = 1'b1;
    @(negedge clk); sw_en_wr = 1'b0;
    kick(8'd2);
    wait_n(200);
    chk(alarm == 1'b0 && sys_rst_n == 1'b1, "R4 software disable", alarm, 0);
    @(negedge clk); sw_en_val = 1'b1; sw_en_wr = 1'b1;
    @(negedge clk); sw_en_wr = 1'b0;
    wait_n(2 * STEP + 6);
    chk(alarm == 1'b1, "R4 software enable", alarm, 1);

    // R4 pin sampled only after reset
    do_reset(1'b0);
    wait_n(20);
    hw_en_pin = 1'b1;
    wait_n(INIT * STEP + 60);
    chk(alarm == 1'b0 && sys_rst_n == 1'b1, "R4 pin ignored after sampling", alarm, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule